// File: doc/BRIEF.md
# Fabric Traffic Counter with Port Filter

This block counts interconnect transactions of one chosen kind and reports the running total through two 64-bit registers on a simple memory-mapped bus. Eight transaction kinds arrive as one pulse line each. Every line carries its own 2-bit tag naming the port that issued the transaction. Software picks the kind to count through the control register. It can count traffic from every port (overall mode) or only from one port (port mode). It can also freeze the count or clear it.

The counter register returns the count in its low bits. Its top nibble echoes the kind code that is currently active. After software changes the selection, it polls this nibble until it matches the new code, and only then trusts the count. Software learns the current mode by reading the filter and port fields back from the control register.

Top module: `fab_traffic_counter`

## Requirements
- R1: After a synchronous active-low reset, the control register (offset 0x20) and the counter register (offset 0x28) both read as zero.
- R2: In the control register, bit 8 (freeze), bits 19:16 (kind code), bits 21:20 (port id) and bit 23 (filter enable) read back as they were last written. Bit 0 and every other bit read as zero.
- R3: The counter register holds the count in bits 59:0 and the echoed kind code in bits 63:60. Writes to offset 0x28 have no effect, and any offset other than 0x20 or 0x28 reads as zero.
- R4: With the filter at 0, the count rises by one at each clock edge where the pulse line whose index equals the kind code is high, whatever its port tag. Codes 0..7 mean: link0 read, link0 write, link1 read, link1 write, coherent-link read, coherent-link write, MMIO read, MMIO write.
- R5: With the filter at 1, a pulse is counted only when its 2-bit port tag equals bits 21:20.
- R6: Pulses on lines that are not selected are ignored. The count rises by at most one per cycle, even when every line pulses at once.
- R7: While the freeze bit is 1, the count holds its value.
- R8: A control write with bit 0 set clears the count at that edge, even when a selected pulse arrives in the same cycle or the count is frozen.
- R9: A control write that changes the kind code, the filter bit or the port id clears the count. A write that leaves all three unchanged, for example one that only toggles freeze, keeps the count.
- R10: The echo field shows a new kind code two clock edges after the edge that wrote it.
- R11: Kind codes 8 to 15 count nothing.
- R12: The count wraps to zero after its maximum value (2^60 - 1 at the default width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| evt_pulse | input | NUM_EVT | One pulse line per transaction kind, indexed by kind code |
| evt_port | input | NUM_EVT*2 | Port tag of each line; line i uses bits 2i+1:2i |

## Verification
The bench builds the block with NUM_EVT at its default of 8, so all eight pulse lines and the unused codes 8 to 15 can be tested. It sets CNT_W to 4, so that the wrap of R12 occurs after sixteen pulses and not after 2^60. The register layout stays fixed, so the echo nibble and the zero bits between it and the count remain observable. With this narrow count, the bench also confirms that the bits above the count field read as zero.

// File: rtl/fab_cnt_pkg.sv
// Package: register layout shared by the fabric traffic counter modules.
// Assumes 64-bit registers; the field positions are fixed by the software view.
package fab_cnt_pkg;
    localparam int REG_W     = 64;
    localparam int CODE_W    = 4;
    localparam int PORT_W    = 2;
    localparam int CLR_BIT   = 0;
    localparam int FRZ_BIT   = 8;
    localparam int CODE_LSB  = 16;
    localparam int PID_LSB   = 20;
    localparam int FILT_BIT  = 23;
    localparam int ECHO_LSB  = REG_W - CODE_W;

    typedef struct packed {
        logic              filt;
        logic [PORT_W-1:0] pid;
        logic [CODE_W-1:0] code;
        logic              frz;
    } ctrl_t;
endpackage

// File: rtl/fab_cnt_regs.sv
// Module: control register of the counter.
// Holds freeze, kind code, port id and filter. Produces a one-cycle clear
// request when software writes bit 0, or when it changes the selection.
// Assumes the write strobe is qualified by the bus for a single cycle.
module fab_cnt_regs
    import fab_cnt_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output ctrl_t             ctrl_q,
    output logic              clr
);
    logic  wr_ctrl;
    ctrl_t ctrl_nxt;
    logic  sel_chg;

    // Decode the write and the new field values.
    always_comb begin
        wr_ctrl       = reg_wr && (reg_addr == CTRL_OFS);
        ctrl_nxt.filt = reg_wdata[FILT_BIT];
        ctrl_nxt.pid  = reg_wdata[PID_LSB +: PORT_W];
        ctrl_nxt.code = reg_wdata[CODE_LSB +: CODE_W];
        ctrl_nxt.frz  = reg_wdata[FRZ_BIT];
        sel_chg       = (ctrl_nxt.code != ctrl_q.code) ||
                        (ctrl_nxt.filt != ctrl_q.filt) ||
                        (ctrl_nxt.pid  != ctrl_q.pid);
        clr           = wr_ctrl && (reg_wdata[CLR_BIT] || sel_chg);
    end

    // Store the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_nxt;
    end
endmodule

// File: rtl/fab_cnt_match.sv
// Module: picks the selected pulse line and applies the port filter.
// Purely combinational. Assumes NUM_EVT <= 2**CODE_W; codes that name no
// line never match.
module fab_cnt_match
    import fab_cnt_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  ctrl_t                      ctrl,
    input  logic [NUM_EVT-1:0]         evt_pulse,
    input  logic [NUM_EVT*PORT_W-1:0]  evt_port,
    output logic                       hit
);
    logic [NUM_EVT-1:0] lane_ok;

    // One filter stage per pulse line.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_lane
        assign lane_ok[i] = evt_pulse[i] &&
            (!ctrl.filt || (evt_port[i*PORT_W +: PORT_W] == ctrl.pid));
    end

    // Select the lane named by the kind code; out-of-range codes give no hit.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (ctrl.code == CODE_W'(i)) hit = lane_ok[i];
        end
    end
endmodule

// File: rtl/fab_cnt_core.sv
// Module: wrapping event count and the two-stage echo of the kind code.
// Clear wins over increment; freeze only blocks increments.
module fab_cnt_core
    import fab_cnt_pkg::*;
#(
    parameter int CNT_W = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hit,
    input  logic              frz,
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CODE_W-1:0] echo_q
);
    logic [CODE_W-1:0] echo_mid;

    // Count selected pulses, wrapping at 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (hit && !frz) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Delay the active code by two edges before it appears in the readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_mid <= '0;
            echo_q   <= '0;
        end else begin
            echo_mid <= code;
            echo_q   <= echo_mid;
        end
    end
endmodule

// File: rtl/fab_traffic_counter.sv
// Module: fabric traffic counter with port filter (top).
// Two 64-bit registers: control at CTRL_OFS and count/echo at CNT_OFS.
// Read data is combinational from reg_addr. Assumes CNT_W <= 64 - CODE_W.
module fab_traffic_counter
    import fab_cnt_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                NUM_EVT  = 8,
    parameter int                CNT_W    = 60,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h20,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [63:0]                reg_wdata,
    output logic [63:0]                reg_rdata,
    input  logic [NUM_EVT-1:0]         evt_pulse,
    input  logic [NUM_EVT*PORT_W-1:0]  evt_port
);
    ctrl_t             ctrl_q;
    logic              clr;
    logic              hit;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] echo_q;

    fab_cnt_regs #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .clr(clr)
    );

    fab_cnt_match #(.NUM_EVT(NUM_EVT)) u_match (
        .ctrl(ctrl_q), .evt_pulse(evt_pulse), .evt_port(evt_port), .hit(hit)
    );

    fab_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit), .frz(ctrl_q.frz),
        .code(ctrl_q.code), .cnt_q(cnt_q), .echo_q(echo_q)
    );

    // Read multiplexer for the two registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[FRZ_BIT]               = ctrl_q.frz;
            reg_rdata[CODE_LSB +: CODE_W]    = ctrl_q.code;
            reg_rdata[PID_LSB +: PORT_W]     = ctrl_q.pid;
            reg_rdata[FILT_BIT]              = ctrl_q.filt;
        end else if (reg_addr == CNT_OFS) begin
            reg_rdata[CNT_W-1:0]             = cnt_q;
            reg_rdata[ECHO_LSB +: CODE_W]    = echo_q;
        end
    end
endmodule

// File: rtl/fab_traffic_counter_chk.sv
// Module: property checker for the fabric traffic counter, bound to the top.
// Observes the clear request, the filtered hit, the count and the echo.
module fab_traffic_counter_chk
    import fab_cnt_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int CNT_W   = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              hit,
    input logic              frz,
    input logic [CODE_W-1:0] code,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] echo
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9

    AST_HIT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !frz && !clr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R4

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !clr) |=> (cnt == $past(cnt))); // R7

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)))); // R6

    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(code) >= NUM_EVT) && !clr) |=> (cnt == $past(cnt))); // R11

    AST_ECHO_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        echo == $past(code, 2)); // R10
endmodule

bind fab_traffic_counter fab_traffic_counter_chk #(
    .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit), .frz(ctrl_q.frz),
    .code(ctrl_q.code), .cnt(cnt_q), .echo(echo_q)
);

// File: tb/fab_traffic_counter_tb.sv
`timescale 1ns/1ps
module fab_traffic_counter_tb;
    localparam int NUM_EVT = 8;
    localparam int CNT_W   = 4;
    localparam logic [7:0] A_CTRL = 8'h20;
    localparam logic [7:0] A_CNT  = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [NUM_EVT-1:0]   evt_pulse = '0;
    logic [NUM_EVT*2-1:0] evt_port = '0;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    fab_traffic_counter #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .evt_port(evt_port)
    );

    // Vector: {ctrl[23:0], pulse mask[7:0], port tags[15:0], expected hit}
    localparam int NV = 10;
    localparam logic [48:0] VEC [NV] = '{
        {24'h000001, 8'h01, 16'h0000, 1'b1},  // R4 code0 overall
        {24'h030001, 8'h08, 16'h0080, 1'b1},  // R4 code3, lane3 port2
        {24'h070001, 8'h80, 16'hC000, 1'b1},  // R4 code7, lane7 port3
        {24'h020001, 8'hFB, 16'hFFFF, 1'b0},  // R6 all but selected
        {24'h050001, 8'hFF, 16'h0000, 1'b1},  // R6 all lines at once
        {24'hA10001, 8'h02, 16'h0008, 1'b1},  // R5 port2, lane1 port2
        {24'hA10001, 8'h02, 16'h0004, 1'b0},  // R5 port2, lane1 port1
        {24'h860001, 8'h40, 16'h0000, 1'b1},  // R5 port0, lane6 port0
        {24'h090001, 8'hFF, 16'h0000, 1'b0},  // R11 code 9
        {24'h0F0001, 8'hFF, 16'h0000, 1'b0}   // R11 code 15
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] m, input logic [15:0] p, input int n);
        evt_pulse = m; evt_port = p;
        repeat (n) @(negedge clk);
        evt_pulse = '0; evt_port = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 64'h0);
        rd(A_CNT, d);  check("R1 cnt", d, 64'h0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [23:0] c;
            c = VEC[v][48:25];
            wr(A_CTRL, {40'h0, c});
            repeat (3) @(negedge clk);
            rd(A_CNT, d);
            check($sformatf("R10 vec%0d echo/zero", v), d, {c[19:16], 60'h0});
            pulse(VEC[v][24:17], VEC[v][16:1], 3);
            rd(A_CNT, d);
            check($sformatf("R4/R5/R6/R11 vec%0d count", v), {4'h0, d[59:0]},
                  VEC[v][0] ? 64'd3 : 64'd0);
        end

        // R2 field readback, bit 0 and stray bits read zero
        wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CTRL, d); check("R2 all-ones readback", d, 64'h0000_0000_00BF_0100);
        wr(A_CTRL, 64'h0000_0000_0037_0001);
        rd(A_CTRL, d); check("R2 readback", d, 64'h0000_0000_0037_0000);

        // R3 counter register read-only, unmapped offset reads zero
        wr(A_CTRL, 64'h0000_0000_0000_0001);
        pulse(8'h01, 16'h0, 5);
        wr(A_CNT, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CNT, d);  check("R3 write ignored", d[59:0], 60'd5);
        rd(8'h30, d);  check("R3 unmapped", d, 64'h0);

        // R7 freeze holds; R9 same selection keeps count
        wr(A_CTRL, 64'h0000_0000_0000_0100);
        rd(A_CNT, d);  check("R9 freeze write keeps count", d[59:0], 60'd5);
        pulse(8'h01, 16'h0, 3);
        rd(A_CNT, d);  check("R7 frozen", d[59:0], 60'd5);
        wr(A_CTRL, 64'h0);
        pulse(8'h01, 16'h0, 2);
        rd(A_CNT, d);  check("R7 unfrozen", d[59:0], 60'd7);

        // R8 clear bit wins over same-cycle pulse, also when frozen
        evt_pulse = 8'h01;
        wr(A_CTRL, 64'h0000_0000_0000_0001);
        evt_pulse = 8'h00;
        rd(A_CNT, d);  check("R8 clear vs pulse", d[59:0], 60'd0);
        pulse(8'h01, 16'h0, 3);
        wr(A_CTRL, 64'h0000_0000_0000_0100);
        wr(A_CTRL, 64'h0000_0000_0000_0101);
        rd(A_CNT, d);  check("R8 clear while frozen", d[59:0], 60'd0);
        wr(A_CTRL, 64'h0);

        // R9 filter change clears, port change clears
        pulse(8'h01, 16'h0, 3);
        wr(A_CTRL, 64'h0000_0000_0080_0000);
        rd(A_CNT, d);  check("R9 filter change", d[59:0], 60'd0);
        pulse(8'h01, 16'h0, 2);
        rd(A_CNT, d);  check("R5 port0 counted", d[59:0], 60'd2);
        wr(A_CTRL, 64'h0000_0000_0090_0000);
        rd(A_CNT, d);  check("R9 port change", d[59:0], 60'd0);

        // R10 echo latency: old code for two edges, new code after the second
        wr(A_CTRL, 64'h0000_0000_0005_0000);
        rd(A_CNT, d);  check("R10 echo edge0", d[63:60], 64'd0);
        @(negedge clk);
        rd(A_CNT, d);  check("R10 echo edge1", d[63:60], 64'd0);
        @(negedge clk);
        rd(A_CNT, d);  check("R10 echo edge2", d[63:60], 64'd5);

        // R12 wrap with the narrow count: 18 pulses leave 2
        wr(A_CTRL, 64'h0000_0000_0000_0001);
        pulse(8'h01, 16'h0, 18);
        rd(A_CNT, d);  check("R12 wrap", d[59:0], 60'd2);

        finish_run();
    end
endmodule